// File: doc/BRIEF.md
# PCI Target Transaction Tracker

This block is the front end of a 32-bit PCI target that answers to one memory window. It watches the shared bus controls, finds every address phase, and claims the memory transactions whose address falls inside its window. It covers address phases that follow the previous transfer with no idle clock between them. It also handles transactions that carry a 64-bit address in two address beats. Once it has claimed a transaction, it drives the device-select, target-ready and stop controls, together with an output enable for each. A local agent paces the data phases through a ready input and asks for a disconnect through a last input. The block reports each completed data phase to the local side, with its address, command, byte enables and data.

The window is set by a 64-bit base and mask. An address hits when the address ANDed with the mask equals the base ANDed with the mask. A one-beat address counts as a 64-bit address whose upper half is zero. Decode timing is medium. Sometimes a claimed address phase follows, with no idle clock, a transfer that a different agent finished. In that case every response is held back by one further clock, so the other target has time to let go of the shared lines.

Top module: `pci_tgt_tracker`

## Requirements
- R1: While reset is held, all three output enables are low and `dp_valid` is low.
- R2: A one-beat address phase with a memory command inside the window asserts DEVSEL# (driven low with its enable high) two clocks after the address clock, and not one clock after. The memory commands are 0110, 0111, 1100, 1110 and 1111.
- R3: A one-beat address outside the window, or one carrying a command that is not a memory command, is never claimed.
- R4: Command code 1101 in the first beat marks a two-beat address. The second beat supplies address bits 63:32 and the real command. A hit is decided on the full 64-bit address, and DEVSEL# falls two clocks after the second beat.
- R5: A two-beat address whose second-beat command is not a memory command (for example I/O 0010, configuration 1011 or interrupt acknowledge 0000) is never claimed.
- R6: A claimed address phase that follows, with no idle clock, a transaction this block did not claim has DEVSEL#, TRDY# and STOP# held off until three clocks after the last address beat.
- R7: A claimed address phase that follows, with no idle clock, a transaction this block claimed gets the normal two-clock timing.
- R8: While selected, TRDY# is low exactly when `loc_ready` is high. `dp_valid` pulses on each clock where TRDY# and IRDY# are both low. On that clock it reports the address, the command, the byte enables as `~C/BE#` and AD as data. The address rises by 4 after each completed phase of a burst.
- R9: When `loc_ready` and `loc_last` are both high, STOP# and TRDY# are low together. That clock's word completes, and no further word is accepted.
- R10: When `loc_last` is high and `loc_ready` is low, STOP# is low, TRDY# is high and no data phase is reported.
- R11: On the clock after the final data phase, DEVSEL#, TRDY# and STOP# are driven high with their enables set. One clock later all three enables are low.
- R12: TRDY# and STOP# are never driven low unless DEVSEL# is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | FRAME# as seen on the bus |
| irdy_n | input | 1 | IRDY# as seen on the bus |
| cbe_n | input | 4 | Command / byte enables, active low |
| ad | input | 32 | Multiplexed address/data |
| trdy_n_bus | input | 1 | Resolved TRDY# on the bus, from all targets |
| stop_n_bus | input | 1 | Resolved STOP# on the bus, from all targets |
| loc_ready | input | 1 | Local side can complete the current data phase |
| loc_last | input | 1 | Local side requests a disconnect |
| devsel_n_o | output | 1 | DEVSEL# drive value |
| devsel_oe | output | 1 | DEVSEL# output enable |
| trdy_n_o | output | 1 | TRDY# drive value |
| trdy_oe | output | 1 | TRDY# output enable |
| stop_n_o | output | 1 | STOP# drive value |
| stop_oe | output | 1 | STOP# output enable |
| dp_valid | output | 1 | A data phase completes this clock |
| dp_addr | output | 64 | Address of the current data phase |
| dp_cmd | output | 4 | Command of the claimed transaction |
| dp_be | output | 4 | Byte enables, active high |
| dp_wdata | output | 32 | Data on AD this clock |

## Verification
The bench builds the block with base 0x0000_0000_8000_0000 and a mask that keeps address bits 63:16, so the window is 64 KiB with a zero upper half. With these values a one-beat address can hit or miss on bit 16. A two-beat address with a zero high word can hit, while a high word of one misses on the upper half alone. A modelled second target completes a transfer on the bus and is immediately followed by an address to this block. That brings both the delayed and the undelayed back-to-back cases within reach.

// File: rtl/pci_tt_pkg.sv
package pci_tt_pkg;

  typedef logic [3:0] cmd_t;

  localparam cmd_t CMD_MEM_RD   = 4'b0110;
  localparam cmd_t CMD_MEM_WR   = 4'b0111;
  localparam cmd_t CMD_MEM_RDM  = 4'b1100;
  localparam cmd_t CMD_DUAL     = 4'b1101;
  localparam cmd_t CMD_MEM_RDL  = 4'b1110;
  localparam cmd_t CMD_MEM_WRI  = 4'b1111;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ADDR_HI = 3'd1,
    ST_DECODE  = 3'd2,
    ST_HOLDOFF = 3'd3,
    ST_XFER    = 3'd4,
    ST_TURN    = 3'd5
  } tgt_state_e;

  function automatic logic is_mem_cmd(input cmd_t c);
    case (c)
      CMD_MEM_RD, CMD_MEM_WR, CMD_MEM_RDM, CMD_MEM_RDL, CMD_MEM_WRI: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pci_tt_bus_tracker.sv
// Follows bus ownership: flags each new address phase (including one that
// arrives the clock after a finished transfer) and remembers who owned the
// transfer that just ended.
module pci_tt_bus_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic trdy_n_bus,
  input  logic stop_n_bus,
  input  logic mine,
  output logic start,
  output logic after_other
);

  logic busy_q, busy_d;
  logic endl_q, endl_d;
  logic prev_mine_q;
  logic bus_end;

  always_comb begin
    bus_end     = busy_q && frame_n && !irdy_n && (!trdy_n_bus || !stop_n_bus);
    start       = !frame_n && !busy_q;
    busy_d      = busy_q;
    if (start) begin
      busy_d = 1'b1;
    end else if (bus_end || (frame_n && irdy_n)) begin
      busy_d = 1'b0;
    end
    endl_d      = bus_end;
    after_other = endl_q && !prev_mine_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      endl_q      <= 1'b0;
      prev_mine_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      endl_q <= endl_d;
      if (bus_end) begin
        prev_mine_q <= mine;
      end
    end
  end

endmodule

// File: rtl/pci_tt_decoder.sv
// Window compare on the full 64-bit address, memory commands only.
module pci_tt_decoder
  import pci_tt_pkg::*;
#(
  parameter int               LA_W = 64,
  parameter logic [LA_W-1:0]  BASE = '0,
  parameter logic [LA_W-1:0]  MASK = '0
) (
  input  logic [LA_W-1:0] addr,
  input  cmd_t            cmd,
  output logic            hit
);

  localparam logic [LA_W-1:0] BASE_M = BASE & MASK;

  assign hit = is_mem_cmd(cmd) && ((addr & MASK) == BASE_M);

endmodule

// File: rtl/pci_tgt_tracker.sv
module pci_tgt_tracker
  import pci_tt_pkg::*;
#(
  parameter int                AD_W     = 32,
  parameter logic [2*AD_W-1:0] WIN_BASE = 64'h0000_0000_8000_0000,
  parameter logic [2*AD_W-1:0] WIN_MASK = 64'hFFFF_FFFF_FFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic [AD_W/8-1:0] cbe_n,
  input  logic [AD_W-1:0]   ad,
  input  logic              trdy_n_bus,
  input  logic              stop_n_bus,
  input  logic              loc_ready,
  input  logic              loc_last,
  output logic              devsel_n_o,
  output logic              devsel_oe,
  output logic              trdy_n_o,
  output logic              trdy_oe,
  output logic              stop_n_o,
  output logic              stop_oe,
  output logic              dp_valid,
  output logic [2*AD_W-1:0] dp_addr,
  output logic [3:0]        dp_cmd,
  output logic [AD_W/8-1:0] dp_be,
  output logic [AD_W-1:0]   dp_wdata
);

  localparam int LA_W = 2 * AD_W;
  localparam int BE_W = AD_W / 8;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  tgt_state_e      st_q, st_d;
  logic [LA_W-1:0] addr_q, addr_d;
  cmd_t            cmd_q, cmd_d;
  logic            dly_q, dly_d;
  logic            trk_start, after_other, hit, in_xfer, phase_done, final_phase;

  assign in_xfer     = (st_q == ST_XFER);
  assign phase_done  = in_xfer && loc_ready && !irdy_n;
  assign final_phase = in_xfer && frame_n && !irdy_n && (loc_ready || loc_last);

  pci_tt_bus_tracker u_trk (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .frame_n     (frame_n),
    .irdy_n      (irdy_n),
    .trdy_n_bus  (trdy_n_bus),
    .stop_n_bus  (stop_n_bus),
    .mine        (in_xfer),
    .start       (trk_start),
    .after_other (after_other)
  );

  pci_tt_decoder #(
    .LA_W (LA_W),
    .BASE (WIN_BASE),
    .MASK (WIN_MASK)
  ) u_dec (
    .addr (addr_q),
    .cmd  (cmd_q),
    .hit  (hit)
  );

  // next state
  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    cmd_d  = cmd_q;
    dly_d  = dly_q;
    if (trk_start) begin
      addr_d = {{AD_W{1'b0}}, ad};
      cmd_d  = cmd_t'(cbe_n);
      dly_d  = after_other;
      st_d   = (cmd_t'(cbe_n) == CMD_DUAL) ? ST_ADDR_HI : ST_DECODE;
    end else begin
      case (st_q)
        ST_ADDR_HI: begin
          addr_d[LA_W-1:AD_W] = ad;
          cmd_d               = cmd_t'(cbe_n);
          st_d                = ST_DECODE;
        end
        ST_DECODE:  st_d = hit ? (dly_q ? ST_HOLDOFF : ST_XFER) : ST_IDLE;
        ST_HOLDOFF: st_d = ST_XFER;
        ST_XFER: begin
          if (phase_done)  addr_d = addr_q + LA_W'(BE_W);
          if (final_phase) st_d   = ST_TURN;
        end
        ST_TURN:    st_d = ST_IDLE;
        default:    st_d = ST_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      cmd_q  <= '0;
      dly_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (trk_start || st_q == ST_ADDR_HI || phase_done) begin
        addr_q <= addr_d;
      end
      if (trk_start || st_q == ST_ADDR_HI) begin
        cmd_q <= cmd_d;
      end
      if (trk_start) begin
        dly_q <= dly_d;
      end
    end
  end

  // pin drive
  always_comb begin
    devsel_oe  = in_xfer || (st_q == ST_TURN);
    trdy_oe    = devsel_oe;
    stop_oe    = devsel_oe;
    devsel_n_o = !in_xfer;
    trdy_n_o   = !(in_xfer && loc_ready);
    stop_n_o   = !(in_xfer && loc_last);
  end

  assign dp_valid = phase_done;
  assign dp_addr  = addr_q;
  assign dp_cmd   = cmd_q;
  assign dp_be    = ~cbe_n;
  assign dp_wdata = ad;

endmodule

// File: rtl/pci_tt_chk.sv
module pci_tt_chk #(
  parameter int LA_W = 64,
  parameter int BE_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            frame_n,
  input logic            irdy_n,
  input logic            trk_start,
  input logic            devsel_n_o,
  input logic            devsel_oe,
  input logic            trdy_n_o,
  input logic            trdy_oe,
  input logic            stop_n_o,
  input logic            stop_oe,
  input logic            dp_valid,
  input logic [LA_W-1:0] dp_addr
);

  logic selected, last_phase;
  assign selected   = devsel_oe && !devsel_n_o;
  assign last_phase = selected && frame_n && !irdy_n && (!trdy_n_o || !stop_n_o);

  assert_sel_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((trdy_oe && !trdy_n_o) || (stop_oe && !stop_n_o)) |-> selected);

  assert_no_fast_claim_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trk_start |=> !selected);

  assert_turn_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    last_phase |=> (devsel_oe && trdy_oe && stop_oe && devsel_n_o && trdy_n_o && stop_n_o));

  assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    last_phase |-> ##2 (!devsel_oe && !trdy_oe && !stop_oe));

  assert_dp_handshake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dp_valid |-> (trdy_oe && !trdy_n_o && !irdy_n && selected));

  assert_burst_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid && !frame_n) |=> (dp_addr == $past(dp_addr) + LA_W'(BE_W)));

  assert_stop_nodata_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_oe && !stop_n_o && trdy_n_o) |-> !dp_valid);

endmodule

bind pci_tgt_tracker pci_tt_chk #(
  .LA_W (LA_W),
  .BE_W (BE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .frame_n    (frame_n),
  .irdy_n     (irdy_n),
  .trk_start  (trk_start),
  .devsel_n_o (devsel_n_o),
  .devsel_oe  (devsel_oe),
  .trdy_n_o   (trdy_n_o),
  .trdy_oe    (trdy_oe),
  .stop_n_o   (stop_n_o),
  .stop_oe    (stop_oe),
  .dp_valid   (dp_valid),
  .dp_addr    (dp_addr)
);

// File: tb/pci_tgt_tracker_tb.sv
`timescale 1ns/1ps
module pci_tgt_tracker_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_n, irdy_n, loc_ready, loc_last;
  logic [3:0]  cbe_n;
  logic [31:0] ad;
  logic        oth_trdy_n = 1'b1;
  logic        oth_stop_n = 1'b1;
  logic        trdy_n_bus, stop_n_bus;
  logic        devsel_n_o, devsel_oe, trdy_n_o, trdy_oe, stop_n_o, stop_oe, dp_valid;
  logic [63:0] dp_addr;
  logic [3:0]  dp_cmd, dp_be;
  logic [31:0] dp_wdata;

  int n_chk = 0;
  int n_err = 0;
  int wd_cnt = 0;

  always #10 clk = ~clk;

  assign trdy_n_bus = trdy_oe ? trdy_n_o : oth_trdy_n;
  assign stop_n_bus = stop_oe ? stop_n_o : oth_stop_n;

  pci_tgt_tracker #(
    .AD_W     (32),
    .WIN_BASE (64'h0000_0000_8000_0000),
    .WIN_MASK (64'hFFFF_FFFF_FFFF_0000)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .cbe_n(cbe_n), .ad(ad),
    .trdy_n_bus(trdy_n_bus), .stop_n_bus(stop_n_bus), .loc_ready(loc_ready), .loc_last(loc_last),
    .devsel_n_o(devsel_n_o), .devsel_oe(devsel_oe), .trdy_n_o(trdy_n_o), .trdy_oe(trdy_oe),
    .stop_n_o(stop_n_o), .stop_oe(stop_oe), .dp_valid(dp_valid), .dp_addr(dp_addr),
    .dp_cmd(dp_cmd), .dp_be(dp_be), .dp_wdata(dp_wdata)
  );

  typedef struct packed {
    logic        dac;
    logic [31:0] lo;
    logic [31:0] hi;
    logic [3:0]  cmd;
    logic        hit;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h8000_0010, 32'h0, 4'h7, 1'b1, 4'd2},  // R2 memory write inside
    '{1'b0, 32'h8000_FFFC, 32'h0, 4'h6, 1'b1, 4'd2},  // R2 top word of window
    '{1'b0, 32'h8001_0000, 32'h0, 4'h6, 1'b0, 4'd3},  // R3 just above window
    '{1'b0, 32'h8000_0020, 32'h0, 4'h2, 1'b0, 4'd3},  // R3 I/O command
    '{1'b1, 32'h8000_0040, 32'h0, 4'h7, 1'b1, 4'd4},  // R4 two-beat hit
    '{1'b1, 32'h8000_0040, 32'h1, 4'h7, 1'b0, 4'd4},  // R4 high word misses
    '{1'b1, 32'h8000_0040, 32'h0, 4'h2, 1'b0, 4'd5},  // R5 I/O in second beat
    '{1'b1, 32'h8000_0040, 32'h0, 4'hB, 1'b0, 4'd5},  // R5 config in second beat
    '{1'b1, 32'h8000_0080, 32'h0, 4'hC, 1'b1, 4'd4},  // R4 read multiple
    '{1'b1, 32'h8000_0080, 32'h0, 4'h0, 1'b0, 4'd5}   // R5 interrupt acknowledge
  };

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic f, input logic i, input logic [31:0] a,
                     input logic [3:0] c, input logic r, input logic l);
    @(negedge clk);
    frame_n = f; irdy_n = i; ad = a; cbe_n = c; loc_ready = r; loc_last = l;
    #1;
  endtask

  function automatic logic sel();
    return devsel_oe && !devsel_n_o;
  endfunction

  task automatic idle();
    cyc(1'b1, 1'b1, 32'h0, 4'hF, 1'b0, 1'b0);
  endtask

  task automatic chk_turn(input string req);
    chk(devsel_oe && trdy_oe && stop_oe && devsel_n_o && trdy_n_o && stop_n_o, req,
        "driven high after final phase",
        {devsel_oe, trdy_oe, stop_oe, devsel_n_o, trdy_n_o, stop_n_o}, 6'b111111);
  endtask

  task automatic chk_float(input string req);
    chk(!devsel_oe && !trdy_oe && !stop_oe, req, "enables released",
        {devsel_oe, trdy_oe, stop_oe}, 3'b000);
  endtask

  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 20000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R1: actual %0d cycles expected fewer than 20000", wd_cnt);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    frame_n = 1'b1; irdy_n = 1'b1; ad = '0; cbe_n = 4'hF; loc_ready = 1'b0; loc_last = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(!devsel_oe && !trdy_oe && !stop_oe, "R1", "enables in reset",
        {devsel_oe, trdy_oe, stop_oe}, 3'b000);
    chk(!dp_valid, "R1", "dp_valid in reset", dp_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) idle();

    // table walk: one data phase per vector
    for (int n = 0; n < NV; n++) begin
      string rq;
      logic [63:0] exp_a;
      rq = $sformatf("R%0d", VECS[n].req);
      exp_a = VECS[n].dac ? {VECS[n].hi, VECS[n].lo} : {32'h0, VECS[n].lo};
      idle();
      if (VECS[n].dac) begin
        cyc(1'b0, 1'b1, VECS[n].lo, 4'hD, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, VECS[n].hi, VECS[n].cmd, 1'b0, 1'b0);
      end else begin
        cyc(1'b0, 1'b1, VECS[n].lo, VECS[n].cmd, 1'b0, 1'b0);
      end
      cyc(1'b1, 1'b0, 32'hA500_0000 + n, 4'b0101, 1'b1, 1'b0);
      chk(!sel(), rq, "no claim one clock after address", sel(), 0);
      cyc(1'b1, 1'b0, 32'hA500_0000 + n, 4'b0101, 1'b1, 1'b0);
      chk(sel() == VECS[n].hit, rq, "claim two clocks after address", sel(), VECS[n].hit);
      if (VECS[n].hit) begin
        chk(dp_valid && !trdy_n_o, "R8", "data phase reported", dp_valid, 1);
        chk(dp_addr == exp_a, "R8", "dp_addr", dp_addr, exp_a);
        chk(dp_cmd == VECS[n].cmd, "R8", "dp_cmd", dp_cmd, VECS[n].cmd);
        chk(dp_be == 4'b1010, "R8", "dp_be", dp_be, 4'b1010);
        chk(dp_wdata == 32'hA500_0000 + n, "R8", "dp_wdata", dp_wdata, 32'hA500_0000 + n);
        idle();
        chk_turn("R11");
        idle();
        chk_float("R11");
      end else begin
        cyc(1'b1, 1'b0, 32'h0, 4'b0101, 1'b1, 1'b0);
        chk(!sel(), rq, "still unclaimed", sel(), 0);
        idle();
      end
    end

    // R8 burst with a wait state
    idle();
    cyc(1'b0, 1'b1, 32'h8000_0100, 4'h7, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 32'hD000_0000, 4'h0, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 32'hD000_0000, 4'h0, 1'b0, 1'b0);
    chk(sel() && trdy_n_o && !dp_valid, "R8", "wait state holds TRDY high",
        {sel(), trdy_n_o, dp_valid}, 3'b110);
    cyc(1'b0, 1'b0, 32'hD000_0000, 4'h0, 1'b1, 1'b0);
    chk(dp_valid && dp_addr == 64'h8000_0100, "R8", "burst word 0", dp_addr, 64'h8000_0100);
    cyc(1'b0, 1'b0, 32'hD000_0001, 4'h0, 1'b1, 1'b0);
    chk(dp_valid && dp_addr == 64'h8000_0104, "R8", "burst word 1", dp_addr, 64'h8000_0104);
    cyc(1'b1, 1'b0, 32'hD000_0002, 4'h0, 1'b1, 1'b0);
    chk(dp_valid && dp_addr == 64'h8000_0108 && dp_wdata == 32'hD000_0002, "R8",
        "burst word 2", dp_addr, 64'h8000_0108);
    idle();
    chk_turn("R11");
    idle();
    chk_float("R11");

    // R9 disconnect with data
    idle();
    cyc(1'b0, 1'b1, 32'h8000_0200, 4'h7, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 32'hE000_0000, 4'h0, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, 32'hE000_0000, 4'h0, 1'b1, 1'b1);
    chk(sel() && !stop_n_o && !trdy_n_o && dp_valid, "R9", "STOP with TRDY, word taken",
        {sel(), stop_n_o, trdy_n_o, dp_valid}, 4'b1001);
    cyc(1'b1, 1'b0, 32'hE000_0001, 4'h0, 1'b0, 1'b1);
    chk(!stop_n_o && trdy_n_o && !dp_valid, "R9", "no further word accepted",
        {stop_n_o, trdy_n_o, dp_valid}, 3'b010);
    idle();
    chk_turn("R11");
    idle();

    // R10 disconnect without data
    idle();
    cyc(1'b0, 1'b1, 32'h8000_0300, 4'h6, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 32'h0, 4'h0, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 32'h0, 4'h0, 1'b0, 1'b1);
    chk(sel() && !stop_n_o && trdy_n_o && !dp_valid, "R10", "STOP without TRDY",
        {sel(), stop_n_o, trdy_n_o, dp_valid}, 4'b1010);
    cyc(1'b1, 1'b0, 32'h0, 4'h0, 1'b0, 1'b1);
    chk(!stop_n_o && !dp_valid, "R10", "final phase without data", {stop_n_o, dp_valid}, 2'b00);
    idle();
    chk_turn("R11");
    idle();

    // R6 / R7 fast back-to-back: another target, then this block twice
    idle();
    cyc(1'b0, 1'b1, 32'h9000_0000, 4'h7, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 32'h1111_0000, 4'h0, 1'b0, 1'b0);
    oth_trdy_n = 1'b0;
    #1;
    chk(!sel(), "R6", "other target's transfer not claimed", sel(), 0);
    cyc(1'b0, 1'b1, 32'h8000_0400, 4'h7, 1'b0, 1'b0);
    oth_trdy_n = 1'b1;
    cyc(1'b1, 1'b0, 32'h2222_0000, 4'h0, 1'b1, 1'b0);
    chk(!sel(), "R6", "no claim at one clock", sel(), 0);
    cyc(1'b1, 1'b0, 32'h2222_0000, 4'h0, 1'b1, 1'b0);
    chk(!devsel_oe && !trdy_oe && !stop_oe, "R6", "held off at two clocks",
        {devsel_oe, trdy_oe, stop_oe}, 3'b000);
    cyc(1'b1, 1'b0, 32'h2222_0000, 4'h0, 1'b1, 1'b0);
    chk(sel() && !trdy_n_o && dp_valid && dp_addr == 64'h8000_0400, "R6",
        "claim at three clocks", dp_addr, 64'h8000_0400);
    cyc(1'b0, 1'b1, 32'h8000_0500, 4'h7, 1'b0, 1'b0);
    chk_turn("R11");
    cyc(1'b1, 1'b0, 32'h3333_0000, 4'h0, 1'b1, 1'b0);
    chk(!sel(), "R7", "no claim at one clock", sel(), 0);
    cyc(1'b1, 1'b0, 32'h3333_0000, 4'h0, 1'b1, 1'b0);
    chk(sel() && dp_valid && dp_addr == 64'h8000_0500, "R7", "normal timing after own",
        dp_addr, 64'h8000_0500);
    idle();
    chk_turn("R11");
    idle();
    chk_float("R11");
    repeat (2) idle();

    summary();
    $finish;
  end

endmodule